// File: doc/BRIEF.md
# MDIO Indirect-Access Management Master

This block is the station-management side of a two-wire management bus. It issues the indirect-access frames that reach registers inside manageable devices on a port. A host presents one request at a time. Each request carries an opcode, a 5-bit port number, a 5-bit device number and a 16-bit word. The word holds a register address for address frames and write data for write frames, and is unused for read frames. The block turns the request into a 64-bit-time frame. It derives the management clock from the system clock with a programmable half-period divider. It drives the serial data line through an output-enable. On reads it releases the line and collects the 16 returned bits.

The host is responsible for the two-step access: an address frame first, then a write or read frame. The block reports busy while a frame is on the wire. It pulses done once when the frame ends. It holds the read word and a turnaround error flag until the next accepted request. Requests carrying the unsupported increment opcode are refused with a one-cycle reject pulse. Requests that arrive while a frame is in progress are ignored.

Top module: `mdio_c45_master`

## Requirements
- R1: A frame starts with 32 one bits, then the start pattern 00, then the 2-bit opcode (00 address, 01 write, 11 read), then the port number and the device number, each sent most significant bit first.
- R2: In address and write frames the master drives 1 and then 0 for the two turnaround bit times, and then the 16-bit word, bit 15 first.
- R3: In read frames the output-enable is low from the first turnaround bit to the end of the frame. The 16 data bits are sampled on the rising management-clock edge, the first sample becoming bit 15 of `rd_data`, and `rd_data` is valid when `done` pulses.
- R4: `rd_err` is set when the line is sampled high in the second turnaround bit of a read. It is cleared when the next frame is accepted.
- R5: A request with opcode 10 made while idle starts no frame and gives a one-cycle `req_reject` pulse in the following cycle.
- R6: A request presented while `busy` is high is ignored: it neither changes the frame in progress nor produces a reject.
- R7: The management clock is low while idle. Each of its half periods lasts `HALF_DIV` system clocks, starting low after acceptance. The data output changes only on its falling edges.
- R8: `busy` rises in the cycle after acceptance and falls after the falling edge that ends bit 63, when `done` pulses for exactly one cycle. While idle the output-enable is low.
- R9: After reset `busy`, `done`, `req_reject`, `rd_err`, `mdc` and `mdio_oe` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_op | input | 2 | Opcode: 00 address, 01 write, 11 read, 10 refused |
| req_port | input | 5 | Port number |
| req_dev | input | 5 | Device number |
| req_word | input | 16 | Register address or write data |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle pulse at frame end |
| req_reject | output | 1 | One-cycle pulse for a refused opcode |
| rd_data | output | 16 | Word returned by the last read |
| rd_err | output | 1 | Turnaround bit of the last read was not low |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Serial data out |
| mdio_oe | output | 1 | Output-enable for the serial data line |
| mdio_i | input | 1 | Serial data in, pulled high when undriven |

## Verification
With half period H and acceptance at edge 0, bit k is presented after edge 2Hk. The rising clock, and the read sample, follow at edge 2Hk+H. The frame ends at edge 128H, where `busy` drops and `done` rises together. `req_reject` appears one edge after the refused request. `rd_err` follows the turnaround sample edge 94H+H. The bench keeps a tick count from acceptance and derives each expected value from it. It compares all outputs at the falling system-clock edge, half a cycle after every register update. The device model presents read data one cycle before each sample edge.

// File: rtl/mdio_c45_pkg.sv
package mdio_c45_pkg;

    localparam int FRAME_BITS = 64;
    localparam int IDX_W      = $clog2(FRAME_BITS);
    localparam int TA_FIRST   = 46;
    localparam int TA_SECOND  = 47;
    localparam int DATA_FIRST = 48;

    typedef enum logic [1:0] {
        OP_ADDR  = 2'b00,
        OP_WRITE = 2'b01,
        OP_INCR  = 2'b10,
        OP_READ  = 2'b11
    } mdio_op_e;

    typedef struct packed {
        mdio_op_e    op;
        logic [4:0]  port;
        logic [4:0]  dev;
        logic [15:0] word;
    } mdio_req_t;

    function automatic logic op_allowed(mdio_op_e op);
        return op != OP_INCR;
    endfunction

    function automatic logic [FRAME_BITS-1:0] build_frame(mdio_req_t r);
        logic [1:0] ta;
        ta = (r.op == OP_READ) ? 2'b11 : 2'b10;
        return {32'hFFFF_FFFF, 2'b00, r.op, r.port, r.dev, ta, r.word};
    endfunction

endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div #(
    parameter int HALF_DIV = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic mdc,
    output logic rise,
    output logic fall
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

    logic [CW-1:0] cnt;
    logic          term;

    assign term = (cnt == CW'(HALF_DIV - 1));
    assign rise = run && term && !mdc;
    assign fall = run && term && mdc;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (term) begin
            cnt <= '0;
            mdc <= ~mdc;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/mdio_frame_shifter.sv
module mdio_frame_shifter
    import mdio_c45_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  load,
    input  logic [FRAME_BITS-1:0] frame_in,
    input  logic                  advance,
    output logic                  bit_out,
    output logic [IDX_W-1:0]      idx,
    output logic                  last
);
    logic [FRAME_BITS-1:0] shreg;

    assign bit_out = shreg[FRAME_BITS-1];
    assign last    = (idx == IDX_W'(FRAME_BITS - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg <= '1;
            idx   <= '0;
        end else if (load) begin
            shreg <= frame_in;
            idx   <= '0;
        end else if (advance) begin
            shreg <= {shreg[FRAME_BITS-2:0], 1'b1};
            idx   <= idx + 1'b1;
        end
    end
endmodule

// File: rtl/mdio_rd_capture.sv
module mdio_rd_capture (
    input  logic        clk,
    input  logic        rst,
    input  logic        clear,
    input  logic        sample_ta,
    input  logic        sample_data,
    input  logic        mdio_i,
    output logic [15:0] rd_data,
    output logic        rd_err
);
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data <= '0;
            rd_err  <= 1'b0;
        end else begin
            if (clear) begin
                rd_err <= 1'b0;
            end else if (sample_ta && mdio_i) begin
                rd_err <= 1'b1;
            end
            if (sample_data) begin
                rd_data <= {rd_data[14:0], mdio_i};
            end
        end
    end
endmodule

// File: rtl/mdio_c45_master.sv
module mdio_c45_master
    import mdio_c45_pkg::*;
#(
    parameter int HALF_DIV = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  logic [1:0]  req_op,
    input  logic [4:0]  req_port,
    input  logic [4:0]  req_dev,
    input  logic [15:0] req_word,
    output logic        busy,
    output logic        done,
    output logic        req_reject,
    output logic [15:0] rd_data,
    output logic        rd_err,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    mdio_req_t        req;
    logic             accept;
    logic             refuse;
    logic             is_read;
    logic             rise;
    logic             fall;
    logic             bit_out;
    logic [IDX_W-1:0] idx;
    logic             last;
    logic             frame_end;

    assign req.op   = mdio_op_e'(req_op);
    assign req.port = req_port;
    assign req.dev  = req_dev;
    assign req.word = req_word;

    assign accept    = req_valid && !busy && op_allowed(req.op);
    assign refuse    = req_valid && !busy && !op_allowed(req.op);
    assign frame_end = busy && fall && last;

    mdio_clk_div #(.HALF_DIV(HALF_DIV)) div_i (
        .clk  (clk),
        .rst  (rst),
        .run  (busy),
        .mdc  (mdc),
        .rise (rise),
        .fall (fall)
    );

    mdio_frame_shifter shift_i (
        .clk      (clk),
        .rst      (rst),
        .load     (accept),
        .frame_in (build_frame(req)),
        .advance  (busy && fall),
        .bit_out  (bit_out),
        .idx      (idx),
        .last     (last)
    );

    mdio_rd_capture cap_i (
        .clk         (clk),
        .rst         (rst),
        .clear       (accept),
        .sample_ta   (busy && is_read && rise && idx == IDX_W'(TA_SECOND)),
        .sample_data (busy && is_read && rise && idx >= IDX_W'(DATA_FIRST)),
        .mdio_i      (mdio_i),
        .rd_data     (rd_data),
        .rd_err      (rd_err)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            busy       <= 1'b0;
            done       <= 1'b0;
            req_reject <= 1'b0;
            is_read    <= 1'b0;
        end else begin
            done       <= frame_end;
            req_reject <= refuse;
            if (accept) begin
                busy    <= 1'b1;
                is_read <= (req.op == OP_READ);
            end else if (frame_end) begin
                busy <= 1'b0;
            end
        end
    end

    assign mdio_o  = busy ? bit_out : 1'b1;
    assign mdio_oe = busy && !(is_read && idx >= IDX_W'(TA_FIRST));
endmodule

// File: rtl/mdio_c45_master_chk.sv
module mdio_c45_master_chk (
    input logic clk,
    input logic rst,
    input logic busy,
    input logic done,
    input logic req_reject,
    input logic mdc,
    input logic mdio_o,
    input logic mdio_oe
);
    AST_OE_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst)
        mdio_oe |-> busy); // R8
    AST_MDC_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mdc); // R7
    AST_DATA_ON_FALL: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy) && !$fell(mdc)) |-> $stable(mdio_o)); // R7
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R8
    AST_DONE_ENDS_FRAME: assert property (@(posedge clk) disable iff (rst)
        done |-> $fell(busy)); // R8
    AST_REJECT_IDLE: assert property (@(posedge clk) disable iff (rst)
        req_reject |-> !busy); // R5
    AST_REJECT_NO_START: assert property (@(posedge clk) disable iff (rst)
        req_reject |=> !busy); // R5
endmodule

bind mdio_c45_master mdio_c45_master_chk chk_i (
    .clk        (clk),
    .rst        (rst),
    .busy       (busy),
    .done       (done),
    .req_reject (req_reject),
    .mdc        (mdc),
    .mdio_o     (mdio_o),
    .mdio_oe    (mdio_oe)
);

// File: tb/mdio_c45_master_tb_top.sv
module mdio_c45_master_tb_top;
    localparam int HALF  = 3;
    localparam int BITC  = 2 * HALF;
    localparam int FRAME = 64 * BITC;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [1:0]  req_op = 2'b00;
    logic [4:0]  req_port = '0;
    logic [4:0]  req_dev = '0;
    logic [15:0] req_word = '0;
    logic        busy, done, req_reject, rd_err, mdc, mdio_o, mdio_oe;
    logic [15:0] rd_data;
    logic        mdio_i = 1'b1;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    mdio_c45_master #(.HALF_DIV(HALF)) dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
        .req_port(req_port), .req_dev(req_dev), .req_word(req_word),
        .busy(busy), .done(done), .req_reject(req_reject), .rd_data(rd_data),
        .rd_err(rd_err), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
        .mdio_i(mdio_i)
    );

    // reference model
    bit          m_busy, m_read, m_done, m_rej, m_err, chk_en;
    int          t;
    logic [63:0] m_frame;
    logic [15:0] dev_word = '0;
    bit          dev_ta_bad = 1'b0;

    always @(posedge clk) begin
        chk_en = 1'b1;
        if (rst) begin
            m_busy = 0; m_read = 0; m_done = 0; m_rej = 0; m_err = 0; t = 0;
        end else begin
            m_done = 0;
            m_rej  = 0;
            if (m_busy) begin
                t++;
                if (m_read && dev_ta_bad && t == 47 * BITC + HALF) m_err = 1;
                if (t == FRAME) begin
                    m_busy = 0;
                    m_done = 1;
                end
            end else if (req_valid) begin
                if (req_op == 2'b10) begin
                    m_rej = 1;
                end else begin
                    m_busy  = 1;
                    t       = 0;
                    m_read  = (req_op == 2'b11);
                    m_err   = 0;
                    m_frame = {32'hFFFF_FFFF, 2'b00, req_op, req_port, req_dev,
                               (req_op == 2'b11) ? 2'b00 : 2'b10, req_word};
                end
            end
        end
    end

    // device model: presents read response bits one cycle ahead of the sample edge
    always @(negedge clk) begin
        int b;
        b = t / BITC;
        if (m_busy && m_read && b == 47)      mdio_i <= dev_ta_bad;
        else if (m_busy && m_read && b >= 48) mdio_i <= dev_word[63 - b];
        else                                  mdio_i <= 1'b1;
    end

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s at %0t: actual %0h expected %0h", req, what, $time, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (chk_en) begin
            int  b;
            bit  e_mdc, e_oe;
            b     = t / BITC;
            e_mdc = m_busy && ((t % BITC) >= HALF);
            e_oe  = m_busy && !(m_read && b >= 46);
            if (rst) begin
                chk("R9", "busy", 32'(busy), 0);
                chk("R9", "done", 32'(done), 0);
                chk("R9", "reject", 32'(req_reject), 0);
                chk("R9", "rd_err", 32'(rd_err), 0);
                chk("R9", "mdc", 32'(mdc), 0);
                chk("R9", "oe", 32'(mdio_oe), 0);
            end else begin
                chk("R8", "busy", 32'(busy), 32'(m_busy));
                chk("R8", "done", 32'(done), 32'(m_done));
                chk("R7", "mdc", 32'(mdc), 32'(e_mdc));
                chk(m_read ? "R3" : "R8", "oe", 32'(mdio_oe), 32'(e_oe));
                if (e_oe) chk(b < 46 ? "R1" : "R2", "mdio_o", 32'(mdio_o), 32'(m_frame[63 - b]));
                chk("R5", "reject", 32'(req_reject), 32'(m_rej));
                chk("R4", "rd_err", 32'(rd_err), 32'(m_err));
                if (m_done && m_read) chk("R3", "rd_data", 32'(rd_data), 32'(dev_word));
            end
        end
    end

    task automatic issue(input logic [1:0] op, input logic [4:0] p, input logic [4:0] d,
                         input logic [15:0] w);
        @(posedge clk); #2;
        req_valid = 1; req_op = op; req_port = p; req_dev = d; req_word = w;
        @(posedge clk); #2;
        req_valid = 0;
    endtask

    task automatic wait_idle();
        @(posedge clk);
        while (m_busy) @(posedge clk);
        #2;
    endtask

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst = 0;
        // R1 R2: address frame
        issue(2'b00, 5'h15, 5'h0A, 16'h1234); wait_idle();
        // R2: write frame with edge-value fields
        issue(2'b01, 5'h1F, 5'h00, 16'hFFFF); wait_idle();
        // R3: read with good turnaround
        dev_word = 16'hA5C3; dev_ta_bad = 0;
        issue(2'b11, 5'h01, 5'h1E, 16'h0000); wait_idle();
        // R4: read with bad turnaround, then cleared by next accept
        dev_word = 16'h0F81; dev_ta_bad = 1;
        issue(2'b11, 5'h10, 5'h03, 16'h0000); wait_idle();
        dev_ta_bad = 0;
        repeat (5) @(posedge clk);
        // R5: refused opcode while idle
        issue(2'b10, 5'h02, 5'h02, 16'hBEEF);
        repeat (4) @(posedge clk);
        // R6: requests during a frame are ignored, including opcode 10
        issue(2'b01, 5'h0C, 5'h11, 16'h8001);
        repeat (50) @(posedge clk);
        issue(2'b11, 5'h03, 5'h04, 16'h5555);
        repeat (20) @(posedge clk);
        issue(2'b10, 5'h03, 5'h04, 16'h5555);
        wait_idle();
        // R8: request held across frame end is taken right after done
        dev_word = 16'h7E01;
        @(posedge clk); #2;
        req_valid = 1; req_op = 2'b00; req_port = 5'h07; req_dev = 5'h07; req_word = 16'h0001;
        @(posedge clk); #2; req_op = 2'b11;
        while (!m_done) @(posedge clk);
        #2; req_valid = 0;
        wait_idle();
        repeat (5) @(posedge clk);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule